// File: doc/BRIEF.md
# Guarded Active-Module Triple Scheduler

This block decides which synapse triples an update engine evaluates in each network step. Triples are grouped into modules. Each module is described by a table entry: an enable bit, the index of its entry (guard) triple, the index of its exit (output) triple, and a contiguous body range given as a base index and a length. Between steps the block watches an observation port that reports triple activations. A 1 on a module's guard triple loads the module into the active pool. A 1 on its output triple unloads it.

On each step request the block applies the pending pool changes and then streams triple indices to the update engine. It walks the modules in ascending order. For every enabled module it emits the guard and output triples, whether or not the module is active, because those are the handshake synapses that must stay observable. For an active module it then emits the body range. The work per step therefore grows with the number of active modules, not with the size of the whole network. Because the output triple of one module can be the guard of the next, a single activation hands control along a chain of sequential modules.

Top module: `triple_pool`

## Requirements
- R1: After reset the pool is empty, `busy`, `out_valid` and `step_done` are 0, and a step streams only handshake triples.
- R2: In every step, for each enabled module in ascending module number, the guard index is streamed and then the output index on the next cycle, regardless of whether the module is active.
- R3: For an active module, the body indices base, base+1, …, base+len−1 follow its output index in ascending order. Body indices of inactive modules are never streamed.
- R4: An observation with `obs_valid`=1, `obs_val`=1 and `obs_idx` equal to an enabled module's guard index makes that module active from the next accepted step onward.
- R5: An observation with `obs_valid`=1, `obs_val`=1 and `obs_idx` equal to an enabled module's output index makes that module inactive from the next accepted step onward.
- R6: Observations with `obs_valid`=0 or `obs_val`=0 leave the pool unchanged.
- R7: If a load and an unload of the same module are both seen before one step boundary, the module ends up active.
- R8: The pool changes only when a step request is accepted. Observations made while a step is streaming take effect at the following step.
- R9: Several modules can be active at once, and all their bodies are streamed in the same step.
- R10: A `step_start` while `busy` is 1 is ignored. `step_done` is a one-cycle pulse in the cycle after the last streamed index, and `busy` is 0 in the cycle after it.
- R11: A table write replaces the module's entry and clears its active and pending state. A module written with enable 0 streams nothing. Writes are made only while `busy` is 0.
- R12: An active module with length 0 streams only its guard and output indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Module table write strobe |
| cfg_mod | input | MOD_W | Module number to write |
| cfg_en | input | 1 | Enable bit of the written entry |
| cfg_guard | input | TIDX_W | Guard triple index |
| cfg_out | input | TIDX_W | Output triple index |
| cfg_base | input | TIDX_W | First body triple index |
| cfg_len | input | LEN_W | Number of body triples |
| obs_valid | input | 1 | Observation strobe |
| obs_idx | input | TIDX_W | Observed triple index |
| obs_val | input | 1 | Observed triple carries a 1 |
| step_start | input | 1 | Step request |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | Step finished pulse |
| out_valid | output | 1 | `out_idx` holds a triple to evaluate |
| out_idx | output | TIDX_W | Streamed triple index |
| out_mod | output | MOD_W | Module owning the streamed index |

## Verification
The checker assumes that table writes arrive only while the block is idle. Its pool-update properties rely on this, because a write in the same cycle as an accepted step would legitimately clear a bit the step just set. The bench issues every write between steps, after `step_done`, and drives observations and requests on the falling edge. It checks the whole ordered index stream of each step against a stream it builds from its own copy of the table and an expected pool mask. That mask is written by hand for each stimulus row.

// File: rtl/tpool_pkg.sv
package tpool_pkg;

    localparam int TIDX_W = 8;
    localparam int LEN_W  = 6;

    typedef logic [TIDX_W-1:0] tidx_t;
    typedef logic [LEN_W-1:0]  tlen_t;

    typedef struct packed {
        logic  en;
        tidx_t guard;
        tidx_t outt;
        tidx_t base;
        tlen_t len;
    } mod_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_GUARD,
        ST_OUTT,
        ST_BODY,
        ST_FIN
    } scan_st_t;

    function automatic tidx_t body_idx(tidx_t base, tlen_t off);
        return base + tidx_t'(off);
    endfunction

endpackage

// File: rtl/tpool_table.sv
module tpool_table
    import tpool_pkg::*;
#(
    parameter int NUM_MODS = 8,
    parameter int MOD_W    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [MOD_W-1:0] wmod,
    input  mod_entry_t wdata,
    output mod_entry_t tbl [NUM_MODS]
);

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_ent
        mod_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (we && wmod == MOD_W'(g)) begin
                ent_q <= wdata;
            end
        end
        assign tbl[g] = ent_q;
    end

endmodule

// File: rtl/tpool_member.sv
module tpool_member
    import tpool_pkg::*;
#(
    parameter int NUM_MODS = 8,
    parameter int MOD_W    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  mod_entry_t tbl [NUM_MODS],
    input  logic       obs_valid,
    input  tidx_t      obs_idx,
    input  logic       obs_val,
    input  logic       start_acc,
    input  logic       cfg_we,
    input  logic [MOD_W-1:0] cfg_mod,
    output logic [NUM_MODS-1:0] act_map,
    output logic [NUM_MODS-1:0] load_vec,
    output logic [NUM_MODS-1:0] unload_vec
);

    logic [NUM_MODS-1:0] pend_ld_q, pend_ul_q, act_q;
    logic [NUM_MODS-1:0] hit_ld, hit_ul, wr_clr, act_next;
    logic                obs_one;

    assign obs_one = obs_valid && obs_val;

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_cmp
        assign hit_ld[g] = obs_one && tbl[g].en && (obs_idx == tbl[g].guard);
        assign hit_ul[g] = obs_one && tbl[g].en && (obs_idx == tbl[g].outt);
    end

    assign load_vec   = pend_ld_q | hit_ld;
    assign unload_vec = pend_ul_q | hit_ul;
    assign wr_clr     = cfg_we ? (NUM_MODS'(1) << cfg_mod) : '0;
    // load takes priority over unload for the same module
    assign act_next   = (act_q & ~unload_vec) | load_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= '0;
            pend_ld_q <= '0;
            pend_ul_q <= '0;
        end else begin
            if (start_acc) begin
                act_q     <= act_next & ~wr_clr;
                pend_ld_q <= '0;
                pend_ul_q <= '0;
            end else begin
                act_q     <= act_q & ~wr_clr;
                pend_ld_q <= load_vec & ~wr_clr;
                pend_ul_q <= unload_vec & ~wr_clr;
            end
        end
    end

    assign act_map = act_q;

endmodule

// File: rtl/tpool_stream.sv
module tpool_stream
    import tpool_pkg::*;
#(
    parameter int NUM_MODS = 8,
    parameter int MOD_W    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  mod_entry_t tbl [NUM_MODS],
    input  logic [NUM_MODS-1:0] act_map,
    input  logic       step_start,
    output logic       start_acc,
    output logic       busy,
    output logic       step_done,
    output logic       out_valid,
    output tidx_t      out_idx,
    output logic [MOD_W-1:0] out_mod
);

    scan_st_t         st_q;
    logic [MOD_W-1:0] mod_q;
    tlen_t            cnt_q;
    mod_entry_t       cur;
    logic             last_mod;
    logic             body_end;

    assign cur       = tbl[mod_q];
    assign last_mod  = (mod_q == MOD_W'(NUM_MODS - 1));
    assign body_end  = (cnt_q == cur.len - tlen_t'(1));
    assign start_acc = step_start && (st_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            mod_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (step_start) begin
                        st_q  <= ST_SEL;
                        mod_q <= '0;
                    end
                end
                ST_SEL: begin
                    if (cur.en) begin
                        st_q <= ST_GUARD;
                    end else if (last_mod) begin
                        st_q <= ST_FIN;
                    end else begin
                        mod_q <= mod_q + 1'b1;
                    end
                end
                ST_GUARD: st_q <= ST_OUTT;
                ST_OUTT: begin
                    if (act_map[mod_q] && cur.len != '0) begin
                        st_q  <= ST_BODY;
                        cnt_q <= '0;
                    end else if (last_mod) begin
                        st_q <= ST_FIN;
                    end else begin
                        mod_q <= mod_q + 1'b1;
                        st_q  <= ST_SEL;
                    end
                end
                ST_BODY: begin
                    if (!body_end) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (last_mod) begin
                        st_q <= ST_FIN;
                    end else begin
                        mod_q <= mod_q + 1'b1;
                        st_q  <= ST_SEL;
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_idx   = '0;
        case (st_q)
            ST_GUARD: begin out_valid = 1'b1; out_idx = cur.guard; end
            ST_OUTT:  begin out_valid = 1'b1; out_idx = cur.outt;  end
            ST_BODY:  begin out_valid = 1'b1; out_idx = body_idx(cur.base, cnt_q); end
            default:  ;
        endcase
    end

    assign out_mod   = mod_q;
    assign busy      = (st_q != ST_IDLE);
    assign step_done = (st_q == ST_FIN);

endmodule

// File: rtl/triple_pool.sv
module triple_pool
    import tpool_pkg::*;
#(
    parameter int NUM_MODS = 8,
    localparam int MOD_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MOD_W-1:0]  cfg_mod,
    input  logic              cfg_en,
    input  logic [TIDX_W-1:0] cfg_guard,
    input  logic [TIDX_W-1:0] cfg_out,
    input  logic [TIDX_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              obs_valid,
    input  logic [TIDX_W-1:0] obs_idx,
    input  logic              obs_val,
    input  logic              step_start,
    output logic              busy,
    output logic              step_done,
    output logic              out_valid,
    output logic [TIDX_W-1:0] out_idx,
    output logic [MOD_W-1:0]  out_mod
);

    mod_entry_t          tbl [NUM_MODS];
    mod_entry_t          wdata;
    logic [NUM_MODS-1:0] act_map, load_vec, unload_vec;
    logic                start_acc;

    assign wdata = '{en: cfg_en, guard: cfg_guard, outt: cfg_out,
                     base: cfg_base, len: cfg_len};

    tpool_table #(.NUM_MODS(NUM_MODS), .MOD_W(MOD_W)) u_table (
        .clk(clk), .rst(rst), .we(cfg_we), .wmod(cfg_mod),
        .wdata(wdata), .tbl(tbl)
    );

    tpool_member #(.NUM_MODS(NUM_MODS), .MOD_W(MOD_W)) u_member (
        .clk(clk), .rst(rst), .tbl(tbl),
        .obs_valid(obs_valid), .obs_idx(obs_idx), .obs_val(obs_val),
        .start_acc(start_acc), .cfg_we(cfg_we), .cfg_mod(cfg_mod),
        .act_map(act_map), .load_vec(load_vec), .unload_vec(unload_vec)
    );

    tpool_stream #(.NUM_MODS(NUM_MODS), .MOD_W(MOD_W)) u_stream (
        .clk(clk), .rst(rst), .tbl(tbl), .act_map(act_map),
        .step_start(step_start), .start_acc(start_acc),
        .busy(busy), .step_done(step_done),
        .out_valid(out_valid), .out_idx(out_idx), .out_mod(out_mod)
    );

endmodule

// File: rtl/triple_pool_chk.sv
module triple_pool_chk #(
    parameter int NUM_MODS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                step_done,
    input logic                out_valid,
    input logic                cfg_we,
    input logic                start_acc,
    input logic [NUM_MODS-1:0] act_map,
    input logic [NUM_MODS-1:0] load_vec,
    input logic [NUM_MODS-1:0] unload_vec
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid);

    assert_pool_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!start_acc && !cfg_we) |=> $stable(act_map));

    assert_load_applied_R4: assert property (@(posedge clk) disable iff (rst)
        (start_acc && !cfg_we) |=> ((act_map & $past(load_vec)) == $past(load_vec)));

    assert_unload_applied_R5: assert property (@(posedge clk) disable iff (rst)
        (start_acc && !cfg_we) |=>
            ((act_map & $past(unload_vec & ~load_vec)) == '0));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (start_acc && !cfg_we) |=>
            ((act_map & $past(load_vec & unload_vec)) == $past(load_vec & unload_vec)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        step_done |=> (!busy && !step_done));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_done) |=> busy);

    assert_cfg_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !busy);

endmodule

bind triple_pool triple_pool_chk #(.NUM_MODS(NUM_MODS)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .step_done(step_done),
    .out_valid(out_valid), .cfg_we(cfg_we), .start_acc(start_acc),
    .act_map(act_map), .load_vec(load_vec), .unload_vec(unload_vec)
);

// File: tb/triple_pool_test.sv
`timescale 1ns/1ps
module triple_pool_test;
    import tpool_pkg::*;

    localparam int NM = 8;
    localparam int MW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_en = 0;
    logic [MW-1:0] cfg_mod = '0;
    logic [TIDX_W-1:0] cfg_guard = '0, cfg_out = '0, cfg_base = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic obs_valid = 0, obs_val = 0, step_start = 0;
    logic [TIDX_W-1:0] obs_idx = '0;
    logic busy, step_done, out_valid;
    logic [TIDX_W-1:0] out_idx;
    logic [MW-1:0] out_mod;

    always #2.5 clk = ~clk;

    triple_pool #(.NUM_MODS(NM)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mod(cfg_mod), .cfg_en(cfg_en),
        .cfg_guard(cfg_guard), .cfg_out(cfg_out), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .obs_valid(obs_valid), .obs_idx(obs_idx), .obs_val(obs_val),
        .step_start(step_start), .busy(busy), .step_done(step_done),
        .out_valid(out_valid), .out_idx(out_idx), .out_mod(out_mod)
    );

    int n_chk = 0, n_bad = 0;
    bit b_en [NM];
    int b_g [NM], b_o [NM], b_b [NM], b_l [NM];
    int got [128];
    int n_got;
    bit hung = 0;

    // columns: obs A idx, obs A val, obs B idx, obs B val, expected pool mask
    // idx -1 means no observation
    localparam int VEC [10][5] = '{
        '{-1, 0, -1, 0, 'h0},
        '{10, 1, -1, 0, 'h1},
        '{-1, 0, -1, 0, 'h1},
        '{11, 1, -1, 0, 'h2},
        '{12, 0, -1, 0, 'h2},
        '{12, 1, -1, 0, 'h4},
        '{13, 1, -1, 0, 'h0},
        '{10, 1, 12, 1, 'h5},
        '{13, 1, 12, 1, 'h5},
        '{11, 1, -1, 0, 'h6}
    };

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int m, input bit en, input int g, input int o,
                             input int b, input int l);
        @(negedge clk);
        cfg_we = 1; cfg_mod = MW'(m); cfg_en = en;
        cfg_guard = TIDX_W'(g); cfg_out = TIDX_W'(o);
        cfg_base = TIDX_W'(b); cfg_len = LEN_W'(l);
        @(negedge clk);
        cfg_we = 0;
        b_en[m] = en; b_g[m] = g; b_o[m] = o; b_b[m] = b; b_l[m] = l;
    endtask

    task automatic observe(input int idx, input bit val, input bit vld);
        @(negedge clk);
        obs_valid = vld; obs_idx = TIDX_W'(idx); obs_val = val;
        @(negedge clk);
        obs_valid = 0; obs_val = 0;
    endtask

    // mode 0: plain, 1: observation mid-step, 2: extra step_start mid-step
    task automatic run_step(input int mode, input int mid_idx);
        int guard_cnt;
        @(negedge clk);
        step_start = 1;
        @(negedge clk);
        step_start = 0;
        n_got = 0;
        guard_cnt = 0;
        forever begin
            if (guard_cnt == 0 && mode == 1) begin
                obs_valid = 1; obs_idx = TIDX_W'(mid_idx); obs_val = 1;
            end
            if (guard_cnt == 0 && mode == 2) step_start = 1;
            if (guard_cnt == 1) begin obs_valid = 0; obs_val = 0; step_start = 0; end
            if (out_valid && n_got < 128) begin got[n_got] = int'(out_idx); n_got++; end
            if (step_done) break;
            guard_cnt++;
            if (guard_cnt > 1000) begin hung = 1; break; end
            @(negedge clk);
        end
        obs_valid = 0; obs_val = 0; step_start = 0;
    endtask

    task automatic check_stream(input logic [NM-1:0] mask, input string req);
        int exp [128];
        int n_exp = 0;
        bit ok;
        string sa, se;
        for (int m = 0; m < NM; m++) begin
            if (b_en[m]) begin
                exp[n_exp++] = b_g[m];
                exp[n_exp++] = b_o[m];
                if (mask[m]) for (int k = 0; k < b_l[m]; k++) exp[n_exp++] = b_b[m] + k;
            end
        end
        ok = !hung && (n_exp == n_got);
        sa = ""; se = "";
        for (int i = 0; i < n_got; i++) sa = {sa, $sformatf("%0d ", got[i])};
        for (int i = 0; i < n_exp; i++) begin
            se = {se, $sformatf("%0d ", exp[i])};
            if (ok && got[i] != exp[i]) ok = 0;
        end
        check(ok, req, sa, se);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < NM; m++) begin
            b_en[m] = 0; b_g[m] = 0; b_o[m] = 0; b_b[m] = 0; b_l[m] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset outputs
        check(busy == 0, "R1 busy", $sformatf("%0b", busy), "0");
        check(out_valid == 0, "R1 out_valid", $sformatf("%0b", out_valid), "0");
        check(step_done == 0, "R1 step_done", $sformatf("%0b", step_done), "0");

        // chain of three modules: output of one is the guard of the next
        cfg_write(0, 1, 10, 11, 20, 4);
        cfg_write(1, 1, 11, 12, 30, 3);
        cfg_write(2, 1, 12, 13, 40, 5);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R9
        for (int r = 0; r < 10; r++) begin
            if (VEC[r][0] >= 0) observe(VEC[r][0], VEC[r][1] != 0, 1'b1);
            if (VEC[r][2] >= 0) observe(VEC[r][2], VEC[r][3] != 0, 1'b1);
            run_step(0, 0);
            check_stream(NM'(VEC[r][4]),
                $sformatf("R1 R2 R3 R4 R5 R6 R7 R9 row %0d", r));
        end

        // R8: observation during a step is deferred (pool 0x6 here)
        run_step(1, 12);
        check_stream(8'h06, "R8 step during observation");
        run_step(0, 0);
        check_stream(8'h04, "R8 next step");

        // R10: restart request while busy is ignored
        run_step(2, 0);
        check_stream(8'h04, "R10 single stream");
        @(negedge clk);
        check(busy == 0, "R10 idle after done", $sformatf("%0b", busy), "0");

        // R12: zero-length module
        cfg_write(3, 1, 50, 51, 60, 0);
        observe(50, 1'b1, 1'b1);
        run_step(0, 0);
        check_stream(8'h0C, "R12 zero length");

        // R11: disabling a module removes it from the stream
        cfg_write(2, 0, 12, 13, 40, 5);
        run_step(0, 0);
        check_stream(8'h08, "R11 disabled module");

        // R6: guard index with strobe low
        observe(10, 1'b1, 1'b0);
        run_step(0, 0);
        check_stream(8'h08, "R6 strobe low");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule